// File: doc/BRIEF.md
# Half-Symbol Timing Error Loop

This block recovers symbol timing from a complex baseband stream that carries two samples per symbol. Each sample arrives with a valid flag and a marker that tells an on-time sample from a mid-symbol sample. On-time samples go straight on to the demodulator. From each on-time sample and the two mid-symbol samples on either side of it, the block forms a timing error that does not need any knowledge of the transmitted data. The error is the real part of the conjugated on-time sample times the difference of the two neighbouring mid samples.

The error drives a second-order loop built from two accumulators. The frequency accumulator integrates the error scaled by a second gain. The phase accumulator integrates the error scaled by a first gain and adds the frequency value once per symbol. Both gains are programmable arithmetic right shifts. The phase value steers an external interpolator, and the loop pushes the error toward zero. Outside logic can preload or zero the frequency accumulator at any time, for example with an initial frequency estimate or with an offset derived from the carrier, and this does not touch the phase accumulator.

Stability follows from the effective gains. The loop needs a positive first-order gain. It is critically damped when the square of that gain equals four times the second-order gain, and it rings while converging when the square is smaller.

Top module: `gtl_timing_loop`

## Requirements
- R1: A sample presented with `s_valid`=1 and `s_ontime`=1 appears on `sym_i`/`sym_q` with `sym_valid`=1 in the following cycle. A cycle without such a sample leaves `sym_valid`=0 in the next cycle.
- R2: When a mid sample (`s_valid`=1, `s_ontime`=0) follows an on-time sample, `ted_valid` is 1 in the next cycle. `ted_err` then equals ot_i*(nm_i-pm_i)+ot_q*(nm_q-pm_q). Here ot is the on-time sample, nm is the new mid sample, and pm is the last mid sample received before that on-time sample.
- R3: No error is produced for an on-time sample that had no mid sample before it since reset. No error is produced for a mid sample unless an on-time sample came after the previous mid sample.
- R4: In the cycle after `ted_valid`=1, `freq_acc` becomes freq_acc + (ted_err sign-extended, arithmetic-shifted right by `k2_shift`), unless a load or clear is present.
- R5: In the cycle after `ted_valid`=1, `phase_acc` becomes phase_acc + (ted_err >>> `k1_shift`) + freq_acc, using the value `freq_acc` held before that edge. The sum wraps modulo 2^ACC_W. With `ted_valid`=0 the phase is unchanged.
- R6: `freq_load`=1 makes `freq_acc` equal `freq_load_val` in the next cycle. A load wins over `freq_clear` and over the integrator update in the same cycle.
- R7: `freq_clear`=1 without `freq_load` makes `freq_acc` zero in the next cycle. A load or clear never changes the phase update.
- R8: After reset, `sym_valid`, `ted_valid`, `ted_err`, `phase_acc` and `freq_acc` are all zero.
- R9: The error is exact for full-scale inputs. With W=12, ot=(-2048,-2048), pm=(-2048,-2048) and nm=(2047,2047), the error is -16773120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample present |
| s_ontime | input | 1 | 1 = on-time sample, 0 = mid-symbol sample |
| s_i | input | W | In-phase sample, signed |
| s_q | input | W | Quadrature sample, signed |
| k1_shift | input | $clog2(ACC_W) | Right shift applied for the phase (first-order) gain |
| k2_shift | input | $clog2(ACC_W) | Right shift applied for the frequency (second-order) gain |
| freq_load | input | 1 | Overwrite the frequency accumulator |
| freq_load_val | input | ACC_W | Value to load, signed |
| freq_clear | input | 1 | Zero the frequency accumulator |
| sym_valid | output | 1 | On-time sample output valid |
| sym_i | output | W | On-time in-phase sample |
| sym_q | output | W | On-time quadrature sample |
| ted_valid | output | 1 | Timing error valid |
| ted_err | output | 2W+2 | Timing error, signed |
| phase_acc | output | ACC_W | Phase accumulator for the interpolator |
| freq_acc | output | ACC_W | Frequency accumulator, signed |

## Verification
The assertions check the following on every cycle:
- The one-cycle capture of on-time samples and the absence of output for mid samples.
- That an error only ever follows a mid sample.
- That the phase holds between errors, and that the frequency holds when nothing updates it.
- The load-over-clear priority.

Only the bench's scenarios can show the rest:
- The arithmetic value of the error for specific triples, including full-scale values.
- The pairing rules that suppress the first error and the error for back-to-back mid samples.
- The exact integrator sums under different shifts.
- That a load landing in the same cycle as an error leaves the phase update using the old frequency.
- Phase wrap-around.

// File: rtl/gtl_pkg.sv
`timescale 1ns/1ps
package gtl_pkg;

  typedef enum logic {
    SMP_MID    = 1'b0,
    SMP_ONTIME = 1'b1
  } smp_kind_e;

  // Width of the error so that the worst-case product sum cannot overflow.
  function automatic int ted_width(input int sw);
    return 2 * sw + 2;
  endfunction

endpackage

// File: rtl/gtl_sample_tap.sv
`timescale 1ns/1ps
module gtl_sample_tap
  import gtl_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic                s_ontime,
  input  logic signed [W-1:0] s_i,
  input  logic signed [W-1:0] s_q,
  output logic                sym_valid,
  output logic signed [W-1:0] sym_i,
  output logic signed [W-1:0] sym_q,
  output logic                fire,
  output logic signed [W-1:0] ot_i,
  output logic signed [W-1:0] ot_q,
  output logic signed [W-1:0] pm_i,
  output logic signed [W-1:0] pm_q
);

  smp_kind_e          kind;
  logic               have_mid;
  logic               pending;
  logic signed [W-1:0] last_mid_i;
  logic signed [W-1:0] last_mid_q;

  assign kind = smp_kind_e'(s_ontime);
  // Error event: a mid sample closing a pending on-time sample.
  assign fire = s_valid && (kind == SMP_MID) && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid  <= 1'b0;
      sym_i      <= '0;
      sym_q      <= '0;
      ot_i       <= '0;
      ot_q       <= '0;
      pm_i       <= '0;
      pm_q       <= '0;
      last_mid_i <= '0;
      last_mid_q <= '0;
      have_mid   <= 1'b0;
      pending    <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      if (s_valid) begin
        if (kind == SMP_ONTIME) begin
          sym_valid <= 1'b1;
          sym_i     <= s_i;
          sym_q     <= s_q;
          ot_i      <= s_i;
          ot_q      <= s_q;
          pm_i      <= last_mid_i;
          pm_q      <= last_mid_q;
          pending   <= have_mid;
        end else begin
          last_mid_i <= s_i;
          last_mid_q <= s_q;
          have_mid   <= 1'b1;
          pending    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/gtl_ted.sv
`timescale 1ns/1ps
module gtl_ted #(
  parameter int W  = 12,
  parameter int EW = 2 * W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic signed [W-1:0]  ot_i,
  input  logic signed [W-1:0]  ot_q,
  input  logic signed [W-1:0]  pm_i,
  input  logic signed [W-1:0]  pm_q,
  input  logic signed [W-1:0]  nm_i,
  input  logic signed [W-1:0]  nm_q,
  output logic                 err_valid,
  output logic signed [EW-1:0] err
);

  localparam int DW = W + 1;

  // Re{conj(ot) * (nm - pm)} with every intermediate wide enough to be exact.
  function automatic logic signed [EW-1:0] ted_metric(
    input logic signed [W-1:0] oi, input logic signed [W-1:0] oq,
    input logic signed [W-1:0] pi, input logic signed [W-1:0] pq,
    input logic signed [W-1:0] ni, input logic signed [W-1:0] nq);
    logic signed [DW-1:0] di, dq;
    logic signed [EW-1:0] pr_i, pr_q;
    di   = DW'(ni) - DW'(pi);
    dq   = DW'(nq) - DW'(pq);
    pr_i = EW'(oi) * EW'(di);
    pr_q = EW'(oq) * EW'(dq);
    return pr_i + pr_q;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err       <= '0;
    end else begin
      err_valid <= fire;
      if (fire) begin
        err <= ted_metric(ot_i, ot_q, pm_i, pm_q, nm_i, nm_q);
      end
    end
  end

endmodule

// File: rtl/gtl_loop_filter.sv
`timescale 1ns/1ps
module gtl_loop_filter #(
  parameter int EW    = 26,
  parameter int ACC_W = 32,
  parameter int SHW   = $clog2(ACC_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    err_valid,
  input  logic signed [EW-1:0]    err,
  input  logic [SHW-1:0]          k1_shift,
  input  logic [SHW-1:0]          k2_shift,
  input  logic                    freq_load,
  input  logic signed [ACC_W-1:0] freq_load_val,
  input  logic                    freq_clear,
  output logic [ACC_W-1:0]        phase_acc,
  output logic signed [ACC_W-1:0] freq_acc
);

  logic signed [ACC_W-1:0] err_ext;
  logic signed [ACC_W-1:0] phase_step;
  logic signed [ACC_W-1:0] freq_step;

  generate
    if (ACC_W >= EW) begin : g_sext
      assign err_ext = ACC_W'(err);
    end else begin : g_trunc
      assign err_ext = err[ACC_W-1:0];
    end
  endgenerate

  function automatic logic signed [ACC_W-1:0] gain_shift(
    input logic signed [ACC_W-1:0] v, input logic [SHW-1:0] sh);
    return v >>> sh;
  endfunction

  assign phase_step = gain_shift(err_ext, k1_shift);
  assign freq_step  = gain_shift(err_ext, k2_shift);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_acc <= '0;
      freq_acc  <= '0;
    end else begin
      if (err_valid) begin
        phase_acc <= phase_acc + phase_step + freq_acc;
      end
      if (freq_load) begin
        freq_acc <= freq_load_val;
      end else if (freq_clear) begin
        freq_acc <= '0;
      end else if (err_valid) begin
        freq_acc <= freq_acc + freq_step;
      end
    end
  end

endmodule

// File: rtl/gtl_timing_loop.sv
`timescale 1ns/1ps
module gtl_timing_loop
  import gtl_pkg::*;
#(
  parameter int W     = 12,
  parameter int ACC_W = 32,
  parameter int SHW   = $clog2(ACC_W),
  parameter int EW    = ted_width(W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  input  logic                    s_ontime,
  input  logic signed [W-1:0]     s_i,
  input  logic signed [W-1:0]     s_q,
  input  logic [SHW-1:0]          k1_shift,
  input  logic [SHW-1:0]          k2_shift,
  input  logic                    freq_load,
  input  logic signed [ACC_W-1:0] freq_load_val,
  input  logic                    freq_clear,
  output logic                    sym_valid,
  output logic signed [W-1:0]     sym_i,
  output logic signed [W-1:0]     sym_q,
  output logic                    ted_valid,
  output logic signed [EW-1:0]    ted_err,
  output logic [ACC_W-1:0]        phase_acc,
  output logic signed [ACC_W-1:0] freq_acc
);

  logic                ted_fire;
  logic signed [W-1:0] ot_i, ot_q, pm_i, pm_q;

  gtl_sample_tap #(.W(W)) u_tap (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ontime(s_ontime), .s_i(s_i), .s_q(s_q),
    .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .fire(ted_fire),
    .ot_i(ot_i), .ot_q(ot_q), .pm_i(pm_i), .pm_q(pm_q)
  );

  gtl_ted #(.W(W), .EW(EW)) u_ted (
    .clk(clk), .rst_n(rst_n), .fire(ted_fire),
    .ot_i(ot_i), .ot_q(ot_q), .pm_i(pm_i), .pm_q(pm_q),
    .nm_i(s_i), .nm_q(s_q),
    .err_valid(ted_valid), .err(ted_err)
  );

  gtl_loop_filter #(.EW(EW), .ACC_W(ACC_W), .SHW(SHW)) u_lf (
    .clk(clk), .rst_n(rst_n),
    .err_valid(ted_valid), .err(ted_err),
    .k1_shift(k1_shift), .k2_shift(k2_shift),
    .freq_load(freq_load), .freq_load_val(freq_load_val),
    .freq_clear(freq_clear),
    .phase_acc(phase_acc), .freq_acc(freq_acc)
  );

endmodule

// File: rtl/gtl_checker.sv
`timescale 1ns/1ps
module gtl_checker #(
  parameter int W     = 12,
  parameter int ACC_W = 32,
  parameter int SHW   = $clog2(ACC_W),
  parameter int EW    = 2 * W + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    s_valid,
  input logic                    s_ontime,
  input logic signed [W-1:0]     s_i,
  input logic signed [W-1:0]     s_q,
  input logic                    freq_load,
  input logic signed [ACC_W-1:0] freq_load_val,
  input logic                    freq_clear,
  input logic                    sym_valid,
  input logic signed [W-1:0]     sym_i,
  input logic signed [W-1:0]     sym_q,
  input logic                    ted_valid,
  input logic [ACC_W-1:0]        phase_acc,
  input logic signed [ACC_W-1:0] freq_acc
);

  p_sym_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ontime) |=> (sym_valid && sym_i == $past(s_i) && sym_q == $past(s_q)));

  p_no_sym_on_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ontime) |=> !sym_valid);

  p_err_after_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ted_valid |-> $past(s_valid && !s_ontime));

  p_freq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ted_valid && !freq_load && !freq_clear) |=> $stable(freq_acc));

  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ted_valid |=> $stable(phase_acc));

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |=> (freq_acc == $past(freq_load_val)));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_clear && !freq_load) |=> (freq_acc == '0));

endmodule

bind gtl_timing_loop gtl_checker #(.W(W), .ACC_W(ACC_W), .SHW(SHW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ontime(s_ontime),
  .s_i(s_i), .s_q(s_q), .freq_load(freq_load), .freq_load_val(freq_load_val),
  .freq_clear(freq_clear), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
  .ted_valid(ted_valid), .phase_acc(phase_acc), .freq_acc(freq_acc)
);

// File: tb/gtl_timing_loop_tb.sv
`timescale 1ns/1ps
module gtl_timing_loop_tb_top;

  localparam int W     = 12;
  localparam int ACC_W = 32;
  localparam int SHW   = 5;
  localparam int EW    = 26;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    s_valid = 1'b0;
  logic                    s_ontime = 1'b0;
  logic signed [W-1:0]     s_i = '0;
  logic signed [W-1:0]     s_q = '0;
  logic [SHW-1:0]          k1_shift = 5'd2;
  logic [SHW-1:0]          k2_shift = 5'd6;
  logic                    freq_load = 1'b0;
  logic signed [ACC_W-1:0] freq_load_val = '0;
  logic                    freq_clear = 1'b0;
  logic                    sym_valid;
  logic signed [W-1:0]     sym_i, sym_q;
  logic                    ted_valid;
  logic signed [EW-1:0]    ted_err;
  logic [ACC_W-1:0]        phase_acc;
  logic signed [ACC_W-1:0] freq_acc;

  gtl_timing_loop dut_i (.*);

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // scoreboard queues
  int q_sym_i[$], q_sym_q[$], q_err[$];
  // driver-side pairing model
  int m_lmi = 0, m_lmq = 0, m_oi = 0, m_oq = 0, m_pi = 0, m_pq = 0;
  bit m_have = 0, m_pend = 0;
  // loop model
  int m_ph = 0, m_fr = 0;
  int last_err = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input bit ont, input int vi, input int vq);
    s_valid  = 1'b1;
    s_ontime = ont;
    s_i      = W'(vi);
    s_q      = W'(vq);
    if (ont) begin
      q_sym_i.push_back(vi); q_sym_q.push_back(vq);
      m_oi = vi; m_oq = vq; m_pi = m_lmi; m_pq = m_lmq; m_pend = m_have;
    end else begin
      if (m_pend) q_err.push_back(m_oi * (vi - m_pi) + m_oq * (vq - m_pq));
      m_lmi = vi; m_lmq = vq; m_have = 1; m_pend = 0;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk); #1;
      if (sym_valid) begin
        if (q_sym_i.size() == 0) check(0, "R1/R3 unexpected symbol", int'(sym_i), 0);
        else begin
          int ei, eq;
          ei = q_sym_i.pop_front(); eq = q_sym_q.pop_front();
          check(int'(sym_i) == ei && int'(sym_q) == eq, "R1 symbol", int'(sym_i), ei);
        end
      end
      if (ted_valid) begin
        if (q_err.size() == 0) check(0, "R3 unexpected error", int'(ted_err), 0);
        else begin
          int ee;
          ee = q_err.pop_front();
          last_err = int'(ted_err);
          check(int'(ted_err) == ee, "R2 error value", int'(ted_err), ee);
        end
      end
      check(int'(phase_acc) == m_ph, "R5 phase", int'(phase_acc), m_ph);
      check(int'(freq_acc) == m_fr, "R4/R6/R7 freq", int'(freq_acc), m_fr);
      begin
        int e, nf;
        e  = int'(ted_err);
        nf = m_fr;
        if (ted_valid) begin
          m_ph = m_ph + (e >>> k1_shift) + m_fr;
          nf   = m_fr + (e >>> k2_shift);
        end
        if (freq_load) m_fr = int'(freq_load_val);
        else if (freq_clear) m_fr = 0;
        else m_fr = nf;
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  int lfsr = 32'h1ACE5;
  function automatic int nextv();
    lfsr = (lfsr << 1) ^ (((lfsr >>> 31) ^ (lfsr >>> 21) ^ (lfsr >>> 1) ^ lfsr) & 1);
    return ((lfsr >>> 3) & 32'hFFF) - 2048;
  endfunction

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R8 reset state
    check(!sym_valid && !ted_valid, "R8 valids", int'(sym_valid) + int'(ted_valid), 0);
    check(ted_err == '0, "R8 err", int'(ted_err), 0);
    check(phase_acc == '0 && freq_acc == '0, "R8 accumulators", int'(phase_acc), 0);
    @(negedge clk);

    // R3: on-time first, no preceding mid -> no error; then mid with nothing pending
    put(1, 100, -50);
    put(0, 30, 40);
    put(0, 20, 10);   // back-to-back mid: R3 no error
    put(1, 300, 200);
    put(0, -40, 70);  // error: 300*(-40-20)+200*(70-10)
    idle(3);
    check(last_err == -6000, "R2 hand value", last_err, -6000);

    // R2/R4/R5 stream with gaps
    for (int s = 0; s < 40; s++) begin
      put(1, nextv(), nextv());
      if (s % 7 == 3) idle(2);
      put(0, nextv(), nextv());
    end
    idle(3);

    // different gains
    k1_shift = 5'd0; k2_shift = 5'd0;
    for (int s = 0; s < 10; s++) begin
      put(1, nextv(), nextv());
      put(0, nextv(), nextv());
    end
    idle(3);
    k1_shift = 5'd3; k2_shift = 5'd9;

    // R6: load in the same cycle as ted_valid
    put(1, 500, -500);
    freq_load_val = 32'sd12345;
    freq_load = 1'b1;           // ted_valid will be high with the next edge's cycle
    put(0, 800, 100);           // error produced at this edge
    freq_clear = 1'b1;          // load and clear together while ted_valid is high
    freq_load_val = -32'sd777;
    idle(1);
    freq_load = 1'b0;
    idle(1);                    // R7 clear alone
    freq_clear = 1'b0;
    idle(2);
    check(int'(freq_acc) == 0, "R7 cleared", int'(freq_acc), 0);

    // R9 full-scale triple
    put(0, -2048, -2048);
    put(1, -2048, -2048);
    put(0, 2047, 2047);
    idle(2);
    check(last_err == -16773120, "R9 full scale", last_err, -16773120);

    // R5 wrap: large frequency
    freq_load_val = 32'sh7000_0000;
    freq_load = 1'b1; idle(1); freq_load = 1'b0;
    for (int s = 0; s < 6; s++) begin
      put(1, nextv(), nextv());
      put(0, nextv(), nextv());
    end
    idle(4);
    check(q_sym_i.size() == 0 && q_err.size() == 0, "R1/R2 queues drained",
          q_sym_i.size() + q_err.size(), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule